// File: doc/BRIEF.md
# Memory-Mapped Compare Timer Frame

This block is one register frame of a system timer. It keeps a free-running count, at least 56 bits wide, that never stops and never goes backwards. A virtual view of that count is the physical count minus a 64-bit offset, and the offset is captured from a configuration input while reset is held. Software sees the virtual count as two 32-bit words. A separate word reports the counter frequency, which comes either from a parameter or from an input pin.

The frame also holds two independent one-shot compare timers. One compares against the physical count and the other against the virtual count. Software arms a timer by writing a signed relative delay, and the frame turns that delay into an absolute 64-bit compare point. When the count reaches the compare point, a status bit goes high and stays high. Each timer drives a level interrupt line, which software can gate with an enable bit and a mask bit. Software never acknowledges the interrupt: it silences the line by setting the mask or by clearing the enable.

The register port is a plain 32-bit port with a single-cycle write strobe and a combinational read of the addressed word.

Top module: `tmrf_frame`

## Requirements
- R1: The physical count resets to the parameter `CNT_INIT` and then increases by exactly one on every clock. Writes to any offset, including the count words, never change it. Its width `CNT_W` must lie between 56 and 64 bits.
- R2: Offset 0x08 reads bits 31:0 and offset 0x0C reads bits 63:32 of the virtual count. The virtual count is the physical count minus the offset that was sampled from `cfg_voff` during reset.
- R3: Reads of high word, low word, high word on consecutive cycles show a carry out of the low word as two different high values. A sequence repeated after the carry gives equal high words and the new value.
- R4: Offset 0x10 reads `cfg_freq` when `USE_FREQ_PIN` is 1 and `FREQ_HZ` otherwise. Writes to it are ignored.
- R5: A write to a delay register loads the compare point as the count at that clock edge plus the 32-bit write data sign-extended to 64 bits. The delay registers are at 0x28 for the physical timer, which uses the physical count, and at 0x38 for the virtual timer, which uses the virtual count. Delays from 0xF to 0x7FFFFFFF fire after exactly that many counts, and a negative delay sets the status at once.
- R6: Bit 2 of a timer control word is the status: it is 1 while the timer's count is greater than or equal to its compare point, compared unsigned over 64 bits. Writes do not set it.
- R7: The control words are at 0x2C (physical) and 0x3C (virtual). Bit 0 is the enable and bit 1 is the mask. An interrupt line is high exactly when enable is 1, mask is 0 and status is 1.
- R8: Setting the mask while the status is 1 lowers the interrupt in the next cycle and leaves the status reading 1.
- R9: Clearing the enable lowers the interrupt in the next cycle. A disabled timer still accepts a new delay, and its status follows that delay.
- R10: A delay register reads the compare point minus the current count, truncated to 32 bits.
- R11: After reset both timers have enable 0, mask 0 and an all-ones compare point, so every control word reads 0 and both interrupts are low.
- R12: Offsets that are not mapped read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_voff | input | 64 | Virtual offset, sampled while reset is low |
| cfg_freq | input | 32 | Frequency value, used when USE_FREQ_PIN is 1 |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_phys | output | 1 | Level interrupt of the physical timer |
| irq_virt | output | 1 | Level interrupt of the virtual timer |

## Verification
The hardest case to reach is a carry out of the low count word that falls between two of the three reads software uses. With a zero start, such a carry would take billions of cycles. The bench therefore starts the physical count 512 counts below a 32-bit boundary and picks the offset so that the virtual low word carries early in the run. It then waits until its own model shows the low word one step short of wrapping, and only then issues the high, low, high sequence, so the carry lands between the first two reads every time. The timer corners (the minimum delay of 0xF, the maximum positive delay, a negative delay, and masking or disabling while the status is high) are driven as directed writes. A model compares every output on every clock.

// File: rtl/tmrf_pkg.sv
`timescale 1ns/1ps
package tmrf_pkg;

   localparam int unsigned REG_W = 32;

   // control word bit positions
   localparam int unsigned CTL_EN_BIT  = 0;
   localparam int unsigned CTL_MSK_BIT = 1;
   localparam int unsigned CTL_STS_BIT = 2;

   // frame offsets
   localparam logic [7:0] OFS_CNT_LO   = 8'h08;
   localparam logic [7:0] OFS_CNT_HI   = 8'h0C;
   localparam logic [7:0] OFS_FREQ     = 8'h10;
   localparam logic [7:0] OFS_TMR_BASE = 8'h28;
   localparam logic [7:0] TMR_STRIDE   = 8'h10;
   localparam logic [7:0] SUB_DELAY    = 8'h00;
   localparam logic [7:0] SUB_CTRL     = 8'h04;

   typedef enum int {TMR_PHYS = 0, TMR_VIRT = 1} tmr_kind_e;

   typedef struct packed {
      logic en;
      logic msk;
   } tmr_ctl_t;

   function automatic logic [7:0] tmr_ofs(input int idx, input logic [7:0] sub);
      return OFS_TMR_BASE + 8'(idx) * TMR_STRIDE + sub;
   endfunction

endpackage

// File: rtl/tmrf_count.sv
`timescale 1ns/1ps
module tmrf_count #(
   parameter int unsigned CNT_W    = 64,
   parameter logic [63:0] CNT_INIT = 64'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [63:0] count
);
   localparam int unsigned PAD_W = 64 - CNT_W;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= CNT_INIT[CNT_W-1:0];
      else        cnt_q <= cnt_q + CNT_W'(1);
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign count = cnt_q;
      end else begin : g_pad
         assign count = {{PAD_W{1'b0}}, cnt_q};
      end
   endgenerate

   // R1: the count moves forward by one on every clock once out of reset
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/tmrf_cmp.sv
`timescale 1ns/1ps
module tmrf_cmp
   import tmrf_pkg::*;
#(
   parameter int unsigned DAT_W = 32,
   parameter int unsigned CMP_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMP_W-1:0] now,
   input  logic             wr_delay,
   input  logic             wr_ctrl,
   input  logic [DAT_W-1:0] wdata,
   output logic [DAT_W-1:0] delay_rd,
   output logic [DAT_W-1:0] ctrl_rd,
   output logic             irq
);
   localparam int unsigned EXT_W = CMP_W - DAT_W;

   if (CMP_W <= DAT_W) begin : g_bad_width
      $error("tmrf_cmp: compare width must exceed data width");
   end

   tmr_ctl_t         ctl_q;
   logic [CMP_W-1:0] cval_q;
   logic [CMP_W-1:0] delay_ext;
   logic             status;

   assign delay_ext = {{EXT_W{wdata[DAT_W-1]}}, wdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cval_q <= '1;
      end else begin
         if (wr_ctrl) begin
            ctl_q.en  <= wdata[CTL_EN_BIT];
            ctl_q.msk <= wdata[CTL_MSK_BIT];
         end
         if (wr_delay) cval_q <= now + delay_ext;
      end
   end

   assign status   = (now >= cval_q);
   assign irq      = ctl_q.en & status & ~ctl_q.msk;
   assign delay_rd = DAT_W'(cval_q - now);

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[CTL_EN_BIT]  = ctl_q.en;
      ctrl_rd[CTL_MSK_BIT] = ctl_q.msk;
      ctrl_rd[CTL_STS_BIT] = status;
   end

   // R10: a fresh delay reads back one count lower in the next cycle
   p_delay_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_delay |=> delay_rd == $past(wdata) - DAT_W'(1));

   // R8: setting the mask silences the line in the next cycle
   p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[CTL_MSK_BIT]) |=> !irq);

   // R9: clearing the enable silences the line in the next cycle
   p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[CTL_EN_BIT]) |=> !irq);

   // R6: once reached, the condition stays met until a new delay is loaded
   p_status_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !wr_delay) |=> status);

endmodule

// File: rtl/tmrf_frame.sv
`timescale 1ns/1ps
module tmrf_frame
   import tmrf_pkg::*;
#(
   parameter int unsigned CNT_W        = 64,
   parameter logic [63:0] CNT_INIT     = 64'h0,
   parameter int unsigned ADDR_W       = 8,
   parameter bit          USE_FREQ_PIN = 1'b0,
   parameter logic [31:0] FREQ_HZ      = 32'd50_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       cfg_voff,
   input  logic [31:0]       cfg_freq,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_phys,
   output logic              irq_virt
);
   localparam int unsigned N_TMR = 2;
   localparam int unsigned CMP_W = 64;

   if (CNT_W < 56 || CNT_W > 64) begin : g_bad_cnt_w
      $error("tmrf_frame: CNT_W must be within 56..64");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("tmrf_frame: ADDR_W must be at least 8");
   end

   logic [63:0] phys_cnt;
   logic [63:0] voff_q;
   logic [63:0] virt_cnt;
   logic [31:0] freq_val;

   logic [CMP_W-1:0] tmr_now   [N_TMR];
   logic [31:0]      tmr_delay [N_TMR];
   logic [31:0]      tmr_ctrl  [N_TMR];
   logic [N_TMR-1:0] tmr_irq;
   logic [N_TMR-1:0] hit_delay;
   logic [N_TMR-1:0] hit_ctrl;

   tmrf_count #(
      .CNT_W    (CNT_W),
      .CNT_INIT (CNT_INIT)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .count (phys_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) voff_q <= cfg_voff;
   end

   assign virt_cnt = phys_cnt - voff_q;

   generate
      if (USE_FREQ_PIN) begin : g_freq_pin
         assign freq_val = cfg_freq;
      end else begin : g_freq_param
         logic unused_freq;
         assign unused_freq = ^cfg_freq;
         assign freq_val    = FREQ_HZ;
      end
   endgenerate

   generate
      for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
         if (t == TMR_VIRT) begin : g_src_virt
            assign tmr_now[t] = virt_cnt;
         end else begin : g_src_phys
            assign tmr_now[t] = phys_cnt;
         end

         assign hit_delay[t] = reg_we && (reg_addr == ADDR_W'(tmr_ofs(t, SUB_DELAY)));
         assign hit_ctrl[t]  = reg_we && (reg_addr == ADDR_W'(tmr_ofs(t, SUB_CTRL)));

         tmrf_cmp #(
            .DAT_W (32),
            .CMP_W (CMP_W)
         ) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .now      (tmr_now[t]),
            .wr_delay (hit_delay[t]),
            .wr_ctrl  (hit_ctrl[t]),
            .wdata    (reg_wdata),
            .delay_rd (tmr_delay[t]),
            .ctrl_rd  (tmr_ctrl[t]),
            .irq      (tmr_irq[t])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_CNT_LO)) reg_rdata = virt_cnt[31:0];
      if (reg_addr == ADDR_W'(OFS_CNT_HI)) reg_rdata = virt_cnt[63:32];
      if (reg_addr == ADDR_W'(OFS_FREQ))   reg_rdata = freq_val;
      for (int t = 0; t < N_TMR; t++) begin
         if (reg_addr == ADDR_W'(tmr_ofs(t, SUB_DELAY))) reg_rdata = tmr_delay[t];
         if (reg_addr == ADDR_W'(tmr_ofs(t, SUB_CTRL)))  reg_rdata = tmr_ctrl[t];
      end
   end

   assign irq_phys = tmr_irq[TMR_PHYS];
   assign irq_virt = tmr_irq[TMR_VIRT];

   // R2: the offset captured in reset holds while the frame runs
   p_voff_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> voff_q == $past(voff_q));

endmodule

// File: tb/tb_tmrf_frame.sv
`timescale 1ns/1ps
module tb_tmrf_frame;

   localparam logic [63:0] INIT = 64'h0000_0001_FFFF_FE00;
   localparam logic [63:0] VOFF = 64'hFFFF_FFF0_0000_0000;
   localparam logic [31:0] FREQ = 32'h05F5_E100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cfg_voff = VOFF;
   logic [31:0] cfg_freq = FREQ;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_p, irq_v;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   tmrf_frame #(
      .CNT_INIT     (INIT),
      .USE_FREQ_PIN (1'b1)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_voff  (cfg_voff),
      .cfg_freq  (cfg_freq),
      .reg_we    (we),
      .reg_addr  (addr),
      .reg_wdata (wdata),
      .reg_rdata (rdata),
      .irq_phys  (irq_p),
      .irq_virt  (irq_v)
   );

   // ---------------- reference model ----------------
   logic [63:0] m_cnt, m_voff;
   logic [63:0] m_cval [2];
   bit          m_en [2];
   bit          m_msk [2];
   bit          m_live = 1'b0;

   function automatic logic [63:0] m_now(input int i);
      return (i == 0) ? m_cnt : m_cnt - m_voff;
   endfunction

   function automatic bit m_sts(input int i);
      return m_now(i) >= m_cval[i];
   endfunction

   function automatic logic [31:0] m_ctl(input int i);
      return {29'd0, m_sts(i), m_msk[i], m_en[i]};
   endfunction

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      logic [63:0] v;
      logic [63:0] d0, d1;
      v  = m_cnt - m_voff;
      d0 = m_cval[0] - m_now(0);
      d1 = m_cval[1] - m_now(1);
      case (a)
         8'h08:   return v[31:0];
         8'h0C:   return v[63:32];
         8'h10:   return FREQ;
         8'h28:   return d0[31:0];
         8'h2C:   return m_ctl(0);
         8'h38:   return d1[31:0];
         8'h3C:   return m_ctl(1);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      case (a)
         8'h08, 8'h0C: return "R2";
         8'h10:        return "R4";
         8'h28, 8'h38: return "R10";
         8'h2C, 8'h3C: return "R6";
         default:      return "R12";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt  = INIT;
         m_voff = cfg_voff;
         for (int i = 0; i < 2; i++) begin
            m_cval[i] = '1;
            m_en[i]   = 1'b0;
            m_msk[i]  = 1'b0;
         end
         m_live = 1'b1;
      end else begin
         if (we) begin
            case (addr)
               8'h28: m_cval[0] = m_cnt + {{32{wdata[31]}}, wdata};
               8'h38: m_cval[1] = (m_cnt - m_voff) + {{32{wdata[31]}}, wdata};
               8'h2C: begin m_en[0] = wdata[0]; m_msk[0] = wdata[1]; end
               8'h3C: begin m_en[1] = wdata[0]; m_msk[1] = wdata[1]; end
               default: ;
            endcase
         end
         m_cnt = m_cnt + 64'd1;
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (m_live) begin
         chk(rdata, exp_rd(addr), tag_of(addr));
         chk({31'd0, irq_p}, {31'd0, m_en[0] & ~m_msk[0] & m_sts(0)}, "R7");
         chk({31'd0, irq_v}, {31'd0, m_en[1] & ~m_msk[1] & m_sts(1)}, "R7");
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(posedge clk); #1;
      addr = a;
      @(negedge clk);
      v = rdata;
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      logic [31:0] v, h1, lo, h2;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11: reset state
      rd(8'h2C, v); chk(v, 32'h0, "R11 phys ctrl");
      rd(8'h3C, v); chk(v, 32'h0, "R11 virt ctrl");
      chk({30'd0, irq_p, irq_v}, 32'h0, "R11 irqs");

      // R4: frequency word, write ignored
      rd(8'h10, v); chk(v, FREQ, "R4 freq");
      wr(8'h10, 32'h1234);
      rd(8'h10, v); chk(v, FREQ, "R4 freq after write");

      // R12: unmapped offset
      wr(8'h50, 32'hFFFF_FFFF);
      rd(8'h50, v); chk(v, 32'h0, "R12 unmapped read");
      rd(8'h2C, v); chk(v, 32'h0, "R12 ctrl untouched");

      // R1 / R2: count words, writes to them ignored
      wr(8'h08, 32'h0);
      rd(8'h0C, v); chk(v, 32'h11, "R2 high word");
      rd(8'h08, v); chk(v, 32'hFFFF_FE00 + (m_cnt[31:0] - INIT[31:0]), "R1 low word advances");

      // R3: place the carry between the first two reads
      while (((m_cnt - m_voff) & 64'hFFFF_FFFF) != 64'hFFFF_FFFE) @(negedge clk);
      rd(8'h0C, h1); rd(8'h08, lo); rd(8'h0C, h2);
      chk(h1, 32'h11, "R3 first high");
      chk(lo, 32'h0, "R3 low after carry");
      chk(h2, 32'h12, "R3 second high differs");
      rd(8'h0C, h1); rd(8'h08, lo); rd(8'h0C, h2);
      chk(h2, h1, "R3 retry consistent");
      chk(h1, 32'h12, "R3 retry value");

      // R5 / R10 / R7 / R6: physical timer
      wr(8'h2C, 32'h1);
      wr(8'h28, 32'd20);
      rd(8'h28, v); chk(v, 32'd18, "R10 delay readback");
      chk({31'd0, irq_p}, 32'd0, "R7 not yet");
      repeat (20) @(negedge clk);
      chk({31'd0, irq_p}, 32'd1, "R7 fired");
      rd(8'h2C, v); chk(v, 32'h5, "R6 status set");

      // R8: mask while pending
      wr(8'h2C, 32'h3);
      rd(8'h2C, v); chk(v, 32'h7, "R8 status kept");
      chk({31'd0, irq_p}, 32'd0, "R8 irq dropped");

      // R9: disable, still programmable
      wr(8'h2C, 32'h0);
      rd(8'h2C, v); chk(v, 32'h4, "R9 disabled, status kept");
      chk({31'd0, irq_p}, 32'd0, "R9 irq low");
      wr(8'h28, 32'h7FFF_FFFF);
      rd(8'h28, v); chk(v, 32'h7FFF_FFFD, "R9 max delay loaded");
      rd(8'h2C, v); chk(v, 32'h0, "R9 status follows delay");
      wr(8'h2C, 32'h1);
      rd(8'h2C, v); chk(v, 32'h1, "R9 enabled, far compare");

      // R5: minimum delay fires exactly on time
      wr(8'h28, 32'hF);
      repeat (13) @(posedge clk);
      @(negedge clk); chk({31'd0, irq_p}, 32'd0, "R5 one count early");
      @(posedge clk);
      @(negedge clk); chk({31'd0, irq_p}, 32'd1, "R5 min delay fired");

      // R5: negative delay sets status at once
      wr(8'h28, 32'hFFFF_FFFB);
      rd(8'h28, v); chk(v, 32'hFFFF_FFF9, "R5 negative delay readback");
      rd(8'h2C, v); chk(v, 32'h5, "R5 negative delay status");

      // R5: virtual timer, independent of physical
      wr(8'h2C, 32'h0);
      wr(8'h3C, 32'h1);
      wr(8'h38, 32'd30);
      rd(8'h3C, v); chk(v, 32'h1, "R5 virt armed");
      chk({31'd0, irq_v}, 32'd0, "R5 virt not yet");
      repeat (30) @(negedge clk);
      chk({31'd0, irq_v}, 32'd1, "R5 virt fired");
      chk({31'd0, irq_p}, 32'd0, "R7 phys stays quiet");

      // R11: reset again mid-run
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk({30'd0, irq_p, irq_v}, 32'h0, "R11 irqs in reset");
      rd(8'h3C, v); chk(v, 32'h0, "R11 ctrl in reset");
      @(posedge clk); #1 rst_n = 1'b1;
      rd(8'h0C, v); chk(v, 32'h11, "R11 count restarts");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule